// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block turns one master clock into two synchronous derived clocks. Each output has its own power-of-two prescaler, which divides by 1, 2, 4 or 8 according to a 2-bit code. Output 0 can carry either the raw master clock or its prescaled version, chosen by a select input. Output 1 carries the output of its prescaler, either directly or after a second divider whose ratio is a 10-bit word plus two.

All counting runs in the master clock domain. The prescalers produce one terminal pulse per divided period, and the second divider counts those pulses, so both outputs keep a fixed phase relation to the master clock. A new code, word, select or bypass setting is taken up only at the terminal count of the counter it belongs to, so a setting change never cuts a pulse short. Any output gating is left to logic outside the block.

Top module: `dual_clk_divider`

## Requirements
- R1: Prescaler code 2'b00, 2'b01, 2'b10 and 2'b11 divides the master clock by 1, 2, 4 and 8, on both prescalers.
- R2: With bypass low, output 1 has a period of (word + 2) x P1 master cycles, P1 being the prescaler-1 ratio; word 0 gives 2 and word 1023 gives 1025.
- R3: With bypass high, output 1 equals the prescaler-1 output and the 10-bit word has no effect on it.
- R4: With select low, output 0 follows the master clock; with select high it carries the prescaler-0 output.
- R5: A divided output with period D master cycles is high for floor(D/P)/2 rounded down times P cycles of each period (for a plain prescaler, floor(D/2)), high phase first.
- R6: A ratio of 1 passes the master clock through: the output is high while the master clock is high and low while it is low.
- R7: A changed setting takes effect only at the terminal count of the affected counter; the period in progress completes with the old high and low times.
- R8: While reset is asserted, both outputs are low, and all counters restart from zero.
- R9: Divided outputs change only just after rising master clock edges and hold their value through the rest of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre0_code_i | input | 2 | Prescaler-0 ratio code |
| out0_sel_i | input | 1 | Output 0 source: 0 raw master clock, 1 prescaled |
| pre1_code_i | input | 2 | Prescaler-1 ratio code |
| div_word_i | input | 10 | Second divider word, ratio is word + 2 |
| div_bypass_i | input | 1 | 1 routes prescaler 1 straight to output 1 |
| clk0_o | output | 1 | Derived clock 0 |
| clk1_o | output | 1 | Derived clock 1 |

## Verification
The bench measures high time and period of each output across every prescaler code, odd and even second-stage ratios and both ends of the word range; an off-by-one in the word offset or the half-period compare shows up as a wrong period or a 1/2-cycle duty skew on odd ratios. Bypass is run with words of 0 and 1000 to catch a divider value leaking through. A code change placed right after a rising edge must leave that 8-cycle period intact, which a design that reloads at once would break with a runt pulse. Ratio 1 and the raw-clock select are sampled in both clock phases, since a design that registers them would hold the output high or low across a whole cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // counter width that holds the largest power-of-two ratio of a code
  function automatic int pre_cnt_w(input int code_w);
    return (1 << code_w);
  endfunction

  function automatic int word_cnt_w(input int word_w, input int offset);
    return $clog2((1 << word_w) + offset);
  endfunction
endpackage

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         hi_o,
  output logic         pass_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, div_q, cnt_inc;
  logic         hi_q, pass_q, last;

  assign cnt_inc = cnt_q + W'(1);
  // ratio 0/1 wraps every step; reset value 1 loads div_i on the first step
  assign last    = (div_q <= W'(1)) || (cnt_inc == div_q);
  assign wrap_o  = en_i & last;
  assign hi_o    = hi_q;
  assign pass_o  = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= W'(1);
      hi_q   <= 1'b0;
      pass_q <= 1'b0;
    end else if (en_i) begin
      if (last) begin
        cnt_q  <= '0;
        div_q  <= div_i;
        hi_q   <= (div_i >= W'(2));
        pass_q <= (div_i == W'(1));
      end else begin
        cnt_q <= cnt_inc;
        hi_q  <= (cnt_inc < (div_q >> 1));
      end
    end
  end
endmodule

// File: rtl/clkdiv_prescaler.sv
`timescale 1ns/1ps
module clkdiv_prescaler #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o,
  output logic              hi_o,
  output logic              wrap_o
);
  localparam int CW = clkdiv_pkg::pre_cnt_w(CODE_W);

  logic [CW-1:0] ratio;
  logic          pass;

  assign ratio = CW'(1) << code_i;

  clkdiv_counter #(.W(CW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .div_i  (ratio),
    .hi_o   (hi_o),
    .pass_o (pass),
    .wrap_o (wrap_o)
  );

  // pass flag switches only at a wrap edge, where both legs are high
  assign clk_o = pass ? clk_i : hi_o;
endmodule

// File: rtl/dual_clk_divider.sv
`timescale 1ns/1ps
module dual_clk_divider #(
  parameter int CODE_W = 2,
  parameter int WORD_W = 10,
  parameter int OFFSET = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] pre0_code_i,
  input  logic              out0_sel_i,
  input  logic [CODE_W-1:0] pre1_code_i,
  input  logic [WORD_W-1:0] div_word_i,
  input  logic              div_bypass_i,
  output logic              clk0_o,
  output logic              clk1_o
);
  localparam int NW = clkdiv_pkg::word_cnt_w(WORD_W, OFFSET);
  localparam int NPRE = 2;

  logic [NPRE-1:0][CODE_W-1:0] pre_code;
  logic [NPRE-1:0]             pre_clk, pre_hi, pre_wrap;
  logic [NW-1:0]               n_ratio;
  logic                        n_hi, n_pass, n_wrap;
  logic                        sel0_q, byp_q;

  assign pre_code[0] = pre0_code_i;
  assign pre_code[1] = pre1_code_i;

  for (genvar i = 0; i < NPRE; i++) begin : g_pre
    clkdiv_prescaler #(.CODE_W(CODE_W)) i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (pre_code[i]),
      .clk_o  (pre_clk[i]),
      .hi_o   (pre_hi[i]),
      .wrap_o (pre_wrap[i])
    );
  end

  assign n_ratio = NW'(div_word_i) + NW'(OFFSET);

  clkdiv_counter #(.W(NW)) i_ndiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pre_wrap[1]),
    .div_i  (n_ratio),
    .hi_o   (n_hi),
    .pass_o (n_pass),
    .wrap_o (n_wrap)
  );

  // source selects follow their counters' wraps; reset values keep outputs low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel0_q <= 1'b1;
      byp_q  <= 1'b0;
    end else begin
      if (pre_wrap[0]) sel0_q <= out0_sel_i;
      if (n_wrap)      byp_q  <= div_bypass_i;
    end
  end

  assign clk0_o = sel0_q ? pre_clk[0] : clk_i;
  assign clk1_o = (byp_q | n_pass) ? pre_clk[1] : n_hi;
endmodule

// File: rtl/dual_clk_divider_chk.sv
`timescale 1ns/1ps
module dual_clk_divider_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk0_o,
  input logic clk1_o,
  input logic pre0_hi,
  input logic pre0_wrap,
  input logic pre1_wrap,
  input logic n_hi,
  input logic n_wrap
);
  // R2: second divider steps only on a prescaler-1 terminal
  a_r2_n_steps_on_pre1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_wrap |-> pre1_wrap);

  // R7: a new second-stage period starts only at its terminal count
  a_r7_n_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(n_hi) |-> $past(n_wrap));

  // R7: prescaler-0 high phase starts only at its terminal count
  a_r1_pre0_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre0_hi) |-> $past(pre0_wrap));

  // R8: outputs low under reset
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r8_low_in_reset: assert (!clk0_o && !clk1_o);
    end
  end
endmodule

bind dual_clk_divider dual_clk_divider_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk0_o    (clk0_o),
  .clk1_o    (clk1_o),
  .pre0_hi   (pre_hi[0]),
  .pre0_wrap (pre_wrap[0]),
  .pre1_wrap (pre_wrap[1]),
  .n_hi      (n_hi),
  .n_wrap    (n_wrap)
);

// File: tb/test_dual_clk_divider.sv
`timescale 1ns/1ps
module test_dual_clk_divider;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD = 20000;

  typedef struct packed {
    logic [1:0]  c0;
    logic [1:0]  c1;
    logic [9:0]  word;
    logic        byp;
    logic [13:0] p0;
    logic [13:0] h0;
    logic [13:0] p1;
    logic [13:0] h1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 10'd0,    1'b0, 14'd2, 14'd1, 14'd2,    14'd1},
    '{2'd2, 2'd1, 10'd1,    1'b0, 14'd4, 14'd2, 14'd6,    14'd2},
    '{2'd3, 2'd2, 10'd3,    1'b0, 14'd8, 14'd4, 14'd20,   14'd8},
    '{2'd1, 2'd3, 10'd0,    1'b1, 14'd2, 14'd1, 14'd8,    14'd4},
    '{2'd2, 2'd1, 10'd1000, 1'b1, 14'd4, 14'd2, 14'd2,    14'd1},
    '{2'd3, 2'd0, 10'd1023, 1'b0, 14'd8, 14'd4, 14'd1025, 14'd512},
    '{2'd1, 2'd0, 10'd1,    1'b0, 14'd2, 14'd1, 14'd3,    14'd1},
    '{2'd2, 2'd3, 10'd2,    1'b0, 14'd4, 14'd2, 14'd32,   14'd16}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] c0 = 2'd0, c1 = 2'd0;
  logic       sel0 = 1'b1, byp = 1'b0;
  logic [9:0] word = 10'd0;
  logic       o0, o1;
  int         n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clk_divider i_dual_clk_divider (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pre0_code_i  (c0),
    .out0_sel_i   (sel0),
    .pre1_code_i  (c1),
    .div_word_i   (word),
    .div_bypass_i (byp),
    .clk0_o       (o0),
    .clk1_o       (o1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic smp(input int which, output logic v);
    @(posedge clk);
    #2;
    v = (which == 0) ? o0 : o1;
  endtask

  // skip to the next rising edge of the output, then time one period
  task automatic measure(input int which, output int hi, output int per);
    logic v;
    int   g;
    g = 0; v = 1'b1;
    while (v && g < GUARD) begin smp(which, v); g++; end
    while (!v && g < GUARD) begin smp(which, v); g++; end
    hi = 0;
    while (v && g < GUARD) begin hi++; smp(which, v); g++; end
    per = hi;
    while (!v && g < GUARD) begin per++; smp(which, v); g++; end
  endtask

  // count phase mismatches against the master clock over n cycles
  task automatic follow(input int which, input int n, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      if (((which == 0) ? o0 : o1) !== 1'b1) bad++;
      @(negedge clk); #2;
      if (((which == 0) ? o0 : o1) !== 1'b0) bad++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int hi, per, bad;
    logic v;

    // R8: reset state
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      if (o0 !== 1'b0 || o1 !== 1'b0) bad++;
      @(negedge clk); #2;
      if (o0 !== 1'b0 || o1 !== 1'b0) bad++;
    end
    check(bad == 0, "R8 outputs low in reset", bad, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R5: vector table
    for (int i = 0; i < NV; i++) begin
      c0 = VECS[i].c0; c1 = VECS[i].c1; word = VECS[i].word; byp = VECS[i].byp; sel0 = 1'b1;
      for (int r = 0; r < 3; r++) measure(0, hi, per);
      check(per == int'(VECS[i].p0), "R1 out0 period", per, int'(VECS[i].p0));
      check(hi  == int'(VECS[i].h0), "R5 out0 high",   hi,  int'(VECS[i].h0));
      for (int r = 0; r < 3; r++) measure(1, hi, per);
      check(per == int'(VECS[i].p1), VECS[i].byp ? "R3 out1 period" : "R2 out1 period",
            per, int'(VECS[i].p1));
      check(hi  == int'(VECS[i].h1), "R5 out1 high", hi, int'(VECS[i].h1));
    end

    // R6: ratio 1 passes the master clock
    c0 = 2'd0; sel0 = 1'b1;
    repeat (20) @(posedge clk);
    follow(0, 8, bad);
    check(bad == 0, "R6 out0 ratio 1 follows clock", bad, 0);

    // R4: raw select with a divide-by-8 code
    c0 = 2'd3; sel0 = 1'b0;
    repeat (20) @(posedge clk);
    follow(0, 8, bad);
    check(bad == 0, "R4 out0 raw select", bad, 0);

    // R4: back to prescaled
    sel0 = 1'b1;
    for (int r = 0; r < 3; r++) measure(0, hi, per);
    check(per == 8, "R4 out0 prescaled period", per, 8);

    // R3 R6: bypass with ratio-1 prescaler, word ignored
    c1 = 2'd0; byp = 1'b1; word = 10'd500;
    repeat (1100) @(posedge clk);
    follow(1, 8, bad);
    check(bad == 0, "R3 out1 bypass ratio 1", bad, 0);

    // R9: divided output holds through the cycle
    c0 = 2'd2; sel0 = 1'b1;
    repeat (20) @(posedge clk);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      logic a;
      @(posedge clk); #1; a = o0;
      @(negedge clk); #4;
      if (o0 !== a) bad++;
    end
    check(bad == 0, "R9 out0 stable within cycle", bad, 0);

    // R7: code change mid-period keeps the current period
    c0 = 2'd3;
    for (int r = 0; r < 3; r++) measure(0, hi, per);
    // now just after the first high sample of a period
    c0 = 2'd1;
    hi = 1; v = 1'b1;
    while (v && hi < 100) begin smp(0, v); if (v) hi++; end
    per = hi;
    while (!v && per < 100) begin per++; smp(0, v); end
    check(hi == 4, "R7 old high time kept", hi, 4);
    check(per == 8, "R7 old period kept", per, 8);
    measure(0, hi, per);
    check(per == 2, "R7 new period after wrap", per, 2);

    report();
  end
endmodule